// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Handshake-Cleared Status Flags

This block is a single timer channel. A free-running up-counter is shared by a small set of general registers. Each general register works either as a compare register, which raises its status flag when the counter reaches its value, or as a capture register, which takes a snapshot of the counter when a chosen edge arrives on its capture input. Each general register owns one status flag bit, and each flag can drive an interrupt request line.

Software reaches everything over a simple single-cycle register bus. A flag can only be cleared through a two-step handshake. Software must first read the flag register and see the flag at 1. A later write of 0 to that bit then clears it. A blind write of 0 does nothing. If a new event arrives in the middle of the handshake, the handshake is abandoned, so that the new event is not lost.

Register map (`bus_addr`): 0 = status flags (bit i for channel i); 1 = counter; 2 = control (bit i = mode of channel i, 1 capture / 0 compare; bit 8+i = interrupt enable of channel i); 3 = edge select (bits [2i+1:2i] for channel i); 4+i = general register i.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, all flags, the counter, every general register, the control and edge-select registers and all `irq` outputs are 0.
- R2: The counter adds 1 on each clock edge with `tick` high and wraps from 0xFFFF to 0x0000. A bus write to address 1 loads the counter and takes priority over `tick` in the same cycle.
- R3: In capture mode, a selected edge on `cap_in[i]` copies the counter into general register i and sets flag i. This happens on the third rising clock edge after the input changes: two edges for synchronisation and one for detection.
- R4: Edge select per channel at address 3, bits [2i+1:2i]: 01 = rising only, 10 = falling only, 11 = both, 00 = none. An edge that is not selected leaves the register and the flag unchanged.
- R5: In compare mode, flag i sets when the counter takes a new value (by tick or by bus load) equal to general register i. Each counter value is compared only once, so a cleared flag does not set again while the counter holds still.
- R6: A read of address 0 that returns 1 in bit i arms channel i. A later write to address 0 with bit i = 0 clears flag i and disarms it.
- R7: A write of 0 to bit i without a prior arming read leaves flag i at 1. A write of 1 to bit i never changes the flag and leaves the arming in place.
- R8: When a set event and a valid clear land on the same clock edge, flag i stays 1.
- R9: A set event between the arming read and the clearing write cancels the arming, so the next write of 0 leaves the flag at 1.
- R10: `irq[i]` is high exactly when flag i is 1 and interrupt enable bit 8+i of address 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| cap_in | input | NUM_CH | Asynchronous capture inputs, one per channel |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid in the cycle of the access |
| irq | output | NUM_CH | Interrupt requests, flag AND enable |

## Verification
The assertions assume that every bus access lasts exactly one cycle, that `bus_addr` is stable for that cycle, and that capture inputs change no faster than once every few clocks, so that each change passes through the synchroniser as a distinct edge. The bench drives all bus and `tick` signals at the falling clock edge. It waits at least three edges after toggling a capture input before checking. It keeps random compare targets a few ticks ahead of a freshly loaded counter, so that exactly one match happens per trial. Flags are observed through `irq` wherever a status read would arm the clear handshake by accident.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(3);
  localparam int GR_BASE = 4;
  localparam int IE_POS  = 8;

  logic [CNT_W-1:0]    cnt;
  logic                cnt_fresh;
  logic [NUM_CH-1:0]   mode, ie, flag, arm;
  logic [2*NUM_CH-1:0] esel;
  logic [CNT_W-1:0]    gr [NUM_CH];
  logic [NUM_CH-1:0]   sync1, sync2, prev;
  logic [NUM_CH-1:0]   cap_evt, cmp_evt, set_evt, clr_evt;

  wire wr     = bus_en & bus_wr;
  wire rd     = bus_en & ~bus_wr;
  wire cnt_wr = wr && (bus_addr == A_CNT);
  wire flg_wr = wr && (bus_addr == A_FLAG);
  wire flg_rd = rd && (bus_addr == A_FLAG);
  wire [NUM_CH-1:0] rise = sync2 & ~prev;
  wire [NUM_CH-1:0] fall = ~sync2 & prev;

  assign irq = flag & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      cnt_fresh <= 1'b0;
    end else if (cnt_wr) begin
      cnt <= bus_wdata;
      cnt_fresh <= 1'b1;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      cnt_fresh <= 1'b1;
    end else begin
      cnt_fresh <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; ie <= '0; esel <= '0;
      sync1 <= '0; sync2 <= '0; prev <= '0;
    end else begin
      sync1 <= cap_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (wr && bus_addr == A_CTRL) begin
        mode <= bus_wdata[NUM_CH-1:0];
        ie   <= bus_wdata[IE_POS +: NUM_CH];
      end
      if (wr && bus_addr == A_EDGE) esel <= bus_wdata[2*NUM_CH-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cap_evt[i] = mode[i] & ((esel[2*i] & rise[i]) | (esel[2*i+1] & fall[i]));
      cmp_evt[i] = ~mode[i] & cnt_fresh & (cnt == gr[i]);
      set_evt[i] = cap_evt[i] | cmp_evt[i];
      clr_evt[i] = flg_wr & ~bus_wdata[i] & arm[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      arm  <= '0;
      for (int i = 0; i < NUM_CH; i++) gr[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (cap_evt[i]) gr[i] <= cnt;
        else if (wr && bus_addr == ADDR_W'(GR_BASE + i)) gr[i] <= bus_wdata;
        if (set_evt[i]) flag[i] <= 1'b1;
        else if (clr_evt[i]) flag[i] <= 1'b0;
        if (set_evt[i] || clr_evt[i]) arm[i] <= 1'b0;
        else if (flg_rd && flag[i]) arm[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLAG: bus_rdata = CNT_W'(flag);
      A_CNT:  bus_rdata = cnt;
      A_CTRL: bus_rdata = CNT_W'({ie, {IE_POS{1'b0}}}) | CNT_W'(mode);
      A_EDGE: bus_rdata = CNT_W'(esel);
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (bus_addr == ADDR_W'(GR_BASE + i)) bus_rdata = gr[i];
      end
    endcase
  end

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == '1) |=> (cnt == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R3
    cap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[g] |=> (gr[g] == $past(cnt)));
    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[g]) |-> $past(set_evt[g]));
    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[g]) |-> $past(flg_wr && !bus_wdata[g] && arm[g]));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt[g] && clr_evt[g]) |=> flag[g]);
    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |=> !arm[g]);
  end
endmodule

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [NUM_CH-1:0] cap_in = '0;
  logic bus_en = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [NUM_CH-1:0] irq;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_timer u_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap_in(cap_in),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [15:0] after_ticks(logic [15:0] start, int k);
    return start + 16'(k);
  endfunction

  function automatic logic [15:0] ctrl_word(logic [2:0] md, logic [2:0] en);
    return {5'b0, en, 5'b0, md};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic run_ticks(int k);
    @(negedge clk);
    tick = 1;
    repeat (k) @(negedge clk);
    tick = 0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic toggle_cap(int ch);
    @(negedge clk);
    cap_in[ch] = ~cap_in[ch];
    idle(3);
  endtask

  task automatic clear_all();
    logic [15:0] d;
    rd(0, d);
    wr(0, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d, g, c;
    int k;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(0, d); check("R1 flags", d, 0);
    rd(1, d); check("R1 counter", d, 0);
    rd(2, d); check("R1 control", d, 0);
    rd(4, d); check("R1 gr0", d, 0);
    check("R1 irq", irq, 0);

    wr(4, 16'h1000); wr(5, 16'h2000); wr(6, 16'h3000);
    wr(2, ctrl_word(3'b000, 3'b111));

    // R2 wrap and load priority
    wr(1, 16'hFFFE);
    run_ticks(2);
    rd(1, d); check("R2 wrap", d, after_ticks(16'hFFFE, 2));
    run_ticks(5);
    rd(1, d); check("R2 count", d, 16'h0005);
    @(negedge clk);
    tick = 1; bus_en = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 16'h0100;
    @(negedge clk);
    tick = 0; bus_en = 0; bus_wr = 0;
    rd(1, d); check("R2 load wins", d, 16'h0100);
    clear_all();

    // R5 compare
    wr(1, 16'h0FFD);
    run_ticks(3);
    idle(2);
    check("R5 compare irq", irq, 3'b001);
    rd(0, d); check("R6 read flag", d, 16'h0001);
    wr(0, 16'h0000);
    check("R6 cleared", irq, 3'b000);
    idle(4);
    check("R5 once per value", irq, 3'b000);

    // R7 blind writes
    wr(1, 16'h0FFF);
    run_ticks(1);
    idle(2);
    check("R5 compare again", irq[0], 1);
    wr(0, 16'h0000);
    check("R7 blind zero", irq[0], 1);
    rd(0, d);
    wr(0, 16'h0001);
    check("R7 write one", irq[0], 1);
    wr(0, 16'h0000);
    check("R7 arm kept after write one", irq[0], 0);

    // R10 interrupt enable
    wr(1, 16'h0FFF);
    run_ticks(1);
    idle(2);
    wr(2, ctrl_word(3'b000, 3'b110));
    check("R10 masked", irq[0], 0);
    rd(0, d); check("R10 flag still set", d[0], 1);
    wr(2, ctrl_word(3'b000, 3'b111));
    check("R10 unmasked", irq[0], 1);
    wr(0, 16'h0000);
    check("R10 cleared", irq[0], 0);

    // R3 / R4 capture
    wr(2, ctrl_word(3'b110, 3'b111));
    wr(3, 16'h0024);
    wr(1, 16'h1234);
    toggle_cap(1);
    rd(5, d); check("R3 capture value", d, 16'h1234);
    check("R3 capture flag", irq, 3'b010);
    toggle_cap(2);
    rd(6, d); check("R4 rise ignored on fall-only", d, 16'h3000);
    check("R4 no flag ch2", irq[2], 0);
    wr(1, 16'h4321);
    toggle_cap(2);
    rd(6, d); check("R4 falling capture", d, 16'h4321);
    check("R4 flag ch2", irq[2], 1);
    wr(1, 16'h5555);
    toggle_cap(1);
    rd(5, d); check("R4 fall ignored on rise-only", d, 16'h1234);

    // R8 set and clear on the same edge
    rd(0, d); check("R8 flags before", d, 16'h0006);
    @(negedge clk) cap_in[1] = ~cap_in[1];
    @(negedge clk);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
    check("R8 set wins", irq[1], 1);
    check("R8 ch2 cleared", irq[2], 0);
    wr(0, 16'h0000);
    check("R9 arm cancelled by set", irq[1], 1);

    // R9 event between read and write
    rd(0, d);
    wr(3, 16'h002C);
    toggle_cap(1);
    wr(0, 16'h0000);
    check("R9 new event kept", irq[1], 1);
    clear_all();
    check("R9 then cleared", irq[1], 0);

    // random compare trials on ch0
    for (int t = 0; t < 20; t++) begin
      g = 16'($urandom);
      k = 1 + int'($urandom % 4);
      wr(4, g);
      wr(1, g - 16'(k));
      run_ticks(k);
      idle(2);
      check("R5 random compare", irq[0], 1);
      clear_all();
      check("R6 random clear", irq[0], 0);
    end

    // random capture trials on ch1 (both edges)
    for (int t = 0; t < 20; t++) begin
      c = 16'($urandom);
      wr(1, c);
      toggle_cap(1);
      rd(5, d); check("R3 random capture", d, c);
      check("R4 both edges flag", irq[1], 1);
      clear_all();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule